// File: doc/BRIEF.md
# Parity-Guarded AES Forward Substitution Unit

This unit performs the forward AES byte substitution on a byte that travels with its own parity bit. Each 9-bit input word holds eight data bits and one check bit. The data bits select one of 256 table entries. Each entry holds the substituted byte and the check bit that belongs with it. The parity of the incoming word is tested before the lookup, and the entry read from the table is tested again before it is released.

When both tests pass, the substituted byte leaves with its check bit unchanged. When either test fails, a fixed error word replaces the result and an error flag rises in the same cycle. The error word is built to violate the parity rule, so a later parity check downstream also catches it.

The table is a synchronous-read memory and the result is registered, so a result appears two clock edges after its input. The unit accepts one word per cycle with no gaps.

Top module: `sbox_guard`

## Requirements
- R1: While reset is high and after reset is released, before any input arrives, out_valid is 0, err is 0 and out_word is 0.
- R2: out_valid is high exactly two rising clock edges after in_valid was sampled high, and is low otherwise.
- R3: For an input word of even parity, out_word[7:0] equals the AES forward substitution of in_word[7:0]: the inverse in GF(2^8) modulo x^8+x^4+x^3+x+1 (0 maps to 0), followed by the affine map with constant 0x63. For example, 0x00 gives 0x63 and 0x53 gives 0xED.
- R4: Bit 8 of in_word and of out_word is the parity bit. In a word that passes the checks, bit 8 makes all nine bits even parity.
- R5: An input word with odd parity over its nine bits yields out_word = 9'h001 and err = 1, whatever its data bits are. This holds for a flip of any single one of the nine bits.
- R6: err is 1 on a valid result exactly when out_word is the error word 9'h001. The error word has odd parity.
- R7: The entry read from the table is checked for even parity. For every one of the 256 correctly coded inputs the check passes and err is 0.
- R8: Results issued on consecutive cycles are judged independently. A bad word never taints the result of a good word next to it, and a good word never masks a bad one.
- R9: While out_valid is low, out_word and err hold the values of the last valid result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word present this cycle |
| in_word | input | 9 | Bit 8 is the parity bit, bits 7:0 are the data byte |
| out_valid | output | 1 | Result present this cycle |
| out_word | output | 9 | Substituted byte with its parity bit, or the error word |
| err | output | 1 | A parity check failed for this result |

## Verification
The bench builds the unit with its default error word, 9'h001. With that value a valid result and an error result can never look alike, because they differ in parity. All 256 addresses are applied back to back, so every table entry passes through the output check and is compared against a separate model that finds inverses by search. Single-bit flips in each of the nine positions exercise the input check. Interleaved good and bad words test that results do not leak between adjacent cycles.

// File: rtl/sbox_guard_pkg.sv
package sbox_guard_pkg;
  localparam int DW    = 8;
  localparam int PW    = DW + 1;
  localparam int DEPTH = 1 << DW;
  localparam logic [DW-1:0] AFF_C = 8'h63;

  function automatic logic [DW-1:0] gf_mul(input logic [DW-1:0] a_in, input logic [DW-1:0] b);
    logic [DW-1:0] a;
    logic [DW-1:0] p;
    a = a_in;
    p = '0;
    for (int i = 0; i < DW; i++) begin
      if (b[i]) p = p ^ a;
      a = {a[DW-2:0], 1'b0} ^ (a[DW-1] ? 8'h1B : 8'h00);
    end
    return p;
  endfunction

  // x^254 by repeated squaring; zero stays zero
  function automatic logic [DW-1:0] gf_inv(input logic [DW-1:0] x);
    logic [DW-1:0] sq;
    logic [DW-1:0] r;
    sq = x;
    r  = 8'h01;
    for (int k = 1; k < DW; k++) begin
      sq = gf_mul(sq, sq);
      r  = gf_mul(r, sq);
    end
    return r;
  endfunction

  function automatic logic [DW-1:0] subst(input logic [DW-1:0] x);
    logic [DW-1:0] b;
    logic [DW-1:0] s;
    b = gf_inv(x);
    for (int i = 0; i < DW; i++)
      s[i] = b[i] ^ b[(i+4)%DW] ^ b[(i+5)%DW] ^ b[(i+6)%DW] ^ b[(i+7)%DW] ^ AFF_C[i];
    return s;
  endfunction

  function automatic logic [PW-1:0] table_entry(input logic [DW-1:0] x);
    logic [DW-1:0] s;
    s = subst(x);
    return {^s, s};
  endfunction
endpackage

// File: rtl/sbox_guard_par.sv
module sbox_guard_par #(
  parameter int W = 9
) (
  input  logic [W-1:0] word,
  output logic         odd
);
  // XOR tree over all bits; high means the even-parity rule is broken
  assign odd = ^word;
endmodule

// File: rtl/sbox_guard_rom.sv
module sbox_guard_rom
  import sbox_guard_pkg::*;
#(
  parameter int AW = DW,
  parameter int EW = PW
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  output logic [EW-1:0] q
);
  localparam int N = 1 << AW;

  logic [EW-1:0] mem [N];

  initial begin
    for (int i = 0; i < N; i++)
      mem[i] = table_entry(DW'(i));
  end

  always_ff @(posedge clk) begin
    q <= mem[addr];
  end
endmodule

// File: rtl/sbox_guard.sv
module sbox_guard
  import sbox_guard_pkg::*;
#(
  parameter logic [PW-1:0] ERR_WORD = 9'h001
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [PW-1:0] in_word,
  output logic          out_valid,
  output logic [PW-1:0] out_word,
  output logic          err
);
  logic          in_bad;
  logic          s1_valid;
  logic          s1_bad;
  logic [PW-1:0] rom_q;
  logic          rom_bad;

  sbox_guard_par #(.W(PW)) u_in_chk (
    .word (in_word),
    .odd  (in_bad)
  );

  sbox_guard_rom #(.AW(DW), .EW(PW)) u_rom (
    .clk  (clk),
    .addr (in_word[DW-1:0]),
    .q    (rom_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_bad   <= 1'b0;
    end else begin
      s1_valid <= in_valid;
      s1_bad   <= in_bad;
    end
  end

  sbox_guard_par #(.W(PW)) u_out_chk (
    .word (rom_q),
    .odd  (rom_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      err       <= 1'b0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        if (s1_bad || rom_bad) begin
          out_word <= ERR_WORD;
          err      <= 1'b1;
        end else begin
          out_word <= rom_q;
          err      <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/sbox_guard_chk.sv
module sbox_guard_chk
  import sbox_guard_pkg::*;
#(
  parameter logic [PW-1:0] ERR_WORD = 9'h001
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [PW-1:0] in_word,
  input logic          out_valid,
  input logic [PW-1:0] out_word,
  input logic          err
);
  logic [1:0] age;

  always_ff @(posedge clk) begin
    if (rst) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

  // R5
  bad_input_chk: assert property (@(posedge clk) disable iff (rst)
    ((age >= 2'd2) && $past(in_valid, 2) && (^$past(in_word, 2))) |-> (err && out_word == ERR_WORD));

  // R6
  err_word_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && err) |-> (out_word == ERR_WORD));

  // R4
  even_out_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !err) |-> !(^out_word));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(out_word) && $stable(err)));
endmodule

bind sbox_guard sbox_guard_chk #(.ERR_WORD(ERR_WORD)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_word   (in_word),
  .out_valid (out_valid),
  .out_word  (out_word),
  .err       (err)
);

// File: tb/sim_sbox_guard.sv
module sim_sbox_guard;
  localparam int CLK_NS = 10;
  localparam logic [8:0] ERRW = 9'h001;

  typedef struct {
    logic [8:0] w;
    logic       e;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [8:0] in_word = '0;
  logic       out_valid;
  logic [8:0] out_word;
  logic       err;

  int   nchk = 0;
  int   nfail = 0;
  exp_t sb[$];
  logic [1:0] vhist = '0;
  logic [8:0] last_w = '0;
  logic       last_e = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  sbox_guard u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .out_valid(out_valid), .out_word(out_word), .err(err)
  );

  function automatic logic [7:0] m_mul(input logic [7:0] a_in, input logic [7:0] b);
    logic [7:0] a, p;
    a = a_in; p = '0;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ a;
      a = {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
    end
    return p;
  endfunction

  function automatic logic [7:0] rotl(input logic [7:0] v, input int k);
    return (v << k) | (v >> (8 - k));
  endfunction

  function automatic logic [7:0] m_sub(input logic [7:0] x);
    logic [7:0] inv;
    inv = 8'h00;
    for (int y = 1; y < 256; y++)
      if (m_mul(x, 8'(y)) == 8'h01) inv = 8'(y);
    return inv ^ rotl(inv, 1) ^ rotl(inv, 2) ^ rotl(inv, 3) ^ rotl(inv, 4) ^ 8'h63;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  task automatic send(input logic [8:0] w, input string tag);
    exp_t x;
    logic [7:0] s;
    @(negedge clk);
    in_valid <= 1'b1;
    in_word  <= w;
    if (^w) begin
      x.w = ERRW; x.e = 1'b1;
    end else begin
      s = m_sub(w[7:0]);
      x.w = {^s, s}; x.e = 1'b0;
    end
    x.tag = tag;
    sb.push_back(x);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid <= 1'b0;
    end
  endtask

  function automatic logic [8:0] good(input logic [7:0] d);
    return {^d, d};
  endfunction

  always @(posedge clk) begin
    if (rst) vhist <= '0;
    else vhist <= {vhist[0], in_valid};
  end

  always @(negedge clk) begin
    exp_t x;
    if (!rst) begin
      // R2 output valid follows input valid by two edges
      check(out_valid == vhist[1], "R2 latency", {15'd0, out_valid}, {15'd0, vhist[1]});
      if (out_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R2 unexpected result", {7'd0, out_word}, 16'd0);
        end else begin
          x = sb.pop_front();
          check(out_word == x.w && err == x.e, x.tag, {6'd0, err, out_word}, {6'd0, x.e, x.w});
          // R4 passing words are even parity; R6 error words are odd
          if (!x.e) check(!(^out_word), "R4 parity", {7'd0, out_word}, {7'd0, x.w});
          else check(^out_word, "R6 error word parity", {7'd0, out_word}, {7'd0, ERRW});
        end
        last_w = out_word;
        last_e = err;
      end else begin
        // R9 hold when idle
        check(out_word == last_w && err == last_e, "R9 hold", {6'd0, err, out_word}, {6'd0, last_e, last_w});
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not finish, pending=%0d expected=0", sb.size());
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(out_valid == 1'b0 && err == 1'b0 && out_word == 9'd0, "R1 reset",
          {6'd0, err, out_word} | {out_valid, 15'd0}, 16'd0);
    rst <= 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0 && err == 1'b0 && out_word == 9'd0, "R1 after release",
          {6'd0, err, out_word} | {out_valid, 15'd0}, 16'd0);

    // R3 R7 every table entry, back to back
    for (int d = 0; d < 256; d++) send(good(8'(d)), "R3 R7 substitution");
    idle(3);

    // R5 each of nine bits flipped on several bytes
    for (int b = 0; b < 4; b++) begin
      logic [7:0] d;
      d = (b == 0) ? 8'h00 : (b == 1) ? 8'h53 : (b == 2) ? 8'hFF : 8'hA7;
      for (int k = 0; k < 9; k++) send(good(d) ^ (9'd1 << k), "R5 single-bit fault");
      idle(1);
    end
    idle(2);

    // R8 alternate good and bad words
    for (int i = 0; i < 20; i++) begin
      if (i % 2 == 0) send(good(8'(i * 13 + 1)), "R8 good beside bad");
      else send(good(8'(i * 7)) ^ 9'h100, "R8 bad beside good");
    end
    // R8 bad then a run of good
    send(9'h001, "R8 bad lead");
    send(good(8'h10), "R8 good after bad");
    send(good(8'h11), "R8 good after bad");
    idle(5);

    check(sb.size() == 0, "R2 all results returned", 16'(sb.size()), 16'd0);
    report();
  end
endmodule